// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Unit

This block advances a SHA-1 working state by four rounds in one operation. The state arrives as one 128-bit word of four 32-bit lanes: A, B, C and D. The fifth variable, E, does not travel with the state. It is pre-added into the top lane of the 128-bit message group. A 2-bit function select picks the round function and its constant for all four rounds.

A second operation prepares the message group for the next four-round step. It takes the earlier state's A, rotates it left by 30, and adds it to the group's top lane. The other three lanes pass through unchanged. A hash engine issues one of these operations per step and keeps the schedule, padding and chaining additions elsewhere.

The result is registered. It appears one clock after the request, together with a valid strobe.

Top module: `sha1_quad_round`

## Requirements
- R1: Lane i occupies bits [32i+31:32i]. With `op_i`=0 and `fn_i`=0, the result is the state after four rounds using Ch(b,c,d)=(b&c)^(~b&d) and K=32'h5A827999. Each round computes A'=ROL5(A)+f(B,C,D)+Wterm+K, B'=A, C'=ROL30(B), D'=C. A sits in lane 3 and D in lane 0, for both input and output.
- R2: With `fn_i`=1, all four rounds use Parity (b^c^d) with K=32'h6ED9EBA1.
- R3: With `fn_i`=2, all four rounds use Maj (b&c)^(b&d)^(c&d) with K=32'h8F1BBCDC.
- R4: With `fn_i`=3, all four rounds use Parity with K=32'hCA62C1D6.
- R5: Round 1 uses message lane 3 as its whole Wterm. Rounds 2, 3 and 4 use message lanes 2, 1 and 0 in turn. Each of those adds the E left by the previous round, which is that round's incoming D.
- R6: With `op_i`=1 (E-fold), result lane 3 = `msg_i` lane 3 + ROL30(`state_i` lane 3).
- R7: With `op_i`=1, result lanes 2 to 0 equal `msg_i` lanes 2 to 0.
- R8: `result_o` and `valid_o` update on the clock edge that samples `valid_i` high. `valid_o` is high for exactly the cycles following a cycle with `valid_i` high.
- R9: While `valid_i` is low, `result_o` holds its value whatever the other inputs do.
- R10: While `rst_ni` is low, `result_o` and `valid_o` are zero.
- R11: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 1 | 0 = four rounds, 1 = E-fold |
| fn_i | input | 2 | Round function and constant select |
| state_i | input | 128 | Working state {A,B,C,D}, or the earlier state for E-fold |
| msg_i | input | 128 | Message group, with W+E in lane 3 |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | New state or folded message group |

## Verification
A fault in any round does not stay contained. It propagates into A. A shifts into B, and B shifts rotated into C, so an error in an early round reaches several output lanes. Because the datapath has only one register stage, the corrupted lanes appear at the ports on the very next cycle.

Four chained random steps, each with its E passed through the fold operation, expose faults that appear only when operations are linked. A misplaced E or a wrong lane order stands out as a mismatch against an independent five-variable round model.

// File: rtl/sha1_quad_pkg.sv
package sha1_quad_pkg;
  localparam int unsigned LANE_W    = 32;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned NUM_RNDS  = 4;
  localparam int unsigned VEC_W     = LANE_W * NUM_LANES;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    FN_CH   = 2'd0,
    FN_PAR1 = 2'd1,
    FN_MAJ  = 2'd2,
    FN_PAR3 = 2'd3
  } fn_sel_e;

  typedef enum logic {
    OP_ROUNDS = 1'b0,
    OP_EFOLD  = 1'b1
  } op_e;

  function automatic lane_t rotl5(lane_t x);
    return {x[LANE_W-6:0], x[LANE_W-1:LANE_W-5]};
  endfunction

  function automatic lane_t rotl30(lane_t x);
    return {x[1:0], x[LANE_W-1:2]};
  endfunction

  function automatic lane_t rnd_const(fn_sel_e sel);
    case (sel)
      FN_CH:   return 32'h5A827999;
      FN_PAR1: return 32'h6ED9EBA1;
      FN_MAJ:  return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic lane_t rnd_mix(fn_sel_e sel, lane_t b, lane_t c, lane_t d);
    case (sel)
      FN_CH:   return (b & c) ^ (~b & d);
      FN_MAJ:  return (b & c) ^ (b & d) ^ (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction
endpackage

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_quad_pkg::*;
(
  input  fn_sel_e sel_i,
  input  lane_t   a_i,
  input  lane_t   b_i,
  input  lane_t   c_i,
  input  lane_t   d_i,
  input  lane_t   wterm_i,
  output lane_t   a_o,
  output lane_t   b_o,
  output lane_t   c_o,
  output lane_t   d_o
);
  lane_t mix;

  always_comb begin
    mix = rnd_mix(sel_i, b_i, c_i, d_i);
    a_o = rotl5(a_i) + mix + wterm_i + rnd_const(sel_i);
    b_o = a_i;
    c_o = rotl30(b_i);
    d_o = c_i;
  end
endmodule

// File: rtl/sha1_quad.sv
module sha1_quad
  import sha1_quad_pkg::*;
(
  input  fn_sel_e            sel_i,
  input  logic [VEC_W-1:0]   state_i,
  input  logic [VEC_W-1:0]   msg_i,
  output logic [VEC_W-1:0]   state_o
);
  lane_t a_s [NUM_RNDS+1];
  lane_t b_s [NUM_RNDS+1];
  lane_t c_s [NUM_RNDS+1];
  lane_t d_s [NUM_RNDS+1];

  assign a_s[0] = state_i[3*LANE_W +: LANE_W];
  assign b_s[0] = state_i[2*LANE_W +: LANE_W];
  assign c_s[0] = state_i[1*LANE_W +: LANE_W];
  assign d_s[0] = state_i[0*LANE_W +: LANE_W];

  for (genvar r = 0; r < NUM_RNDS; r++) begin : g_rnd
    lane_t wterm;
    if (r == 0) begin : g_first
      // E already folded into lane 3 upstream
      assign wterm = msg_i[(NUM_LANES-1)*LANE_W +: LANE_W];
    end else begin : g_next
      // previous round's incoming D is this round's E
      assign wterm = msg_i[(NUM_LANES-1-r)*LANE_W +: LANE_W] + d_s[r-1];
    end

    sha1_round u_rnd (
      .sel_i   (sel_i),
      .a_i     (a_s[r]),
      .b_i     (b_s[r]),
      .c_i     (c_s[r]),
      .d_i     (d_s[r]),
      .wterm_i (wterm),
      .a_o     (a_s[r+1]),
      .b_o     (b_s[r+1]),
      .c_o     (c_s[r+1]),
      .d_o     (d_s[r+1])
    );
  end

  assign state_o = {a_s[NUM_RNDS], b_s[NUM_RNDS], c_s[NUM_RNDS], d_s[NUM_RNDS]};
endmodule

// File: rtl/sha1_efold.sv
module sha1_efold
  import sha1_quad_pkg::*;
(
  input  logic [VEC_W-1:0] prev_i,
  input  logic [VEC_W-1:0] grp_i,
  output logic [VEC_W-1:0] grp_o
);
  localparam int unsigned TOP = (NUM_LANES-1)*LANE_W;

  lane_t prev_a;
  lane_t top_sum;

  always_comb begin
    prev_a  = prev_i[TOP +: LANE_W];
    top_sum = grp_i[TOP +: LANE_W] + rotl30(prev_a);
    grp_o   = {top_sum, grp_i[TOP-1:0]};
  end
endmodule

// File: rtl/sha1_quad_round.sv
module sha1_quad_round
  import sha1_quad_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         op_i,
  input  logic [1:0]   fn_i,
  input  logic [127:0] state_i,
  input  logic [127:0] msg_i,
  output logic         valid_o,
  output logic [127:0] result_o
);
  logic [VEC_W-1:0] rnd_res;
  logic [VEC_W-1:0] fold_res;
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_q;
  fn_sel_e          sel;

  assign sel = fn_sel_e'(fn_i);

  sha1_quad u_quad (
    .sel_i   (sel),
    .state_i (state_i),
    .msg_i   (msg_i),
    .state_o (rnd_res)
  );

  sha1_efold u_fold (
    .prev_i (state_i),
    .grp_i  (msg_i),
    .grp_o  (fold_res)
  );

  assign res_d = (op_e'(op_i) == OP_EFOLD) ? fold_res : rnd_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_FOLD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i) |=> result_o[95:0] == $past(msg_i[95:0])); // R7
  AST_FOLD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i) |=> result_o[127:96] ==
      $past(msg_i[127:96] + {state_i[97:96], state_i[127:98]})); // R6
endmodule

// File: tb/sim_sha1_quad_round.sv
module sim_sha1_quad_round;
  typedef struct packed {
    logic         op;
    logic [1:0]   fn;
    logic [127:0] st;
    logic [127:0] msg;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 128'h67452301_EFCDAB89_98BADCFE_10325476, 128'h61626380_00000000_00000000_00000018},
    '{1'b0, 2'd1, 128'h0123ABCD_DEADBEEF_CAFEF00D_13579BDF, 128'h11111111_22222222_33333333_44444444},
    '{1'b0, 2'd2, 128'h89ABCDEF_76543210_FEDCBA98_01234567, 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0},
    '{1'b0, 2'd3, 128'hC3D2E1F0_10325476_98BADCFE_EFCDAB89, 128'h80000000_00000001_7FFFFFFF_FFFFFFFE},
    '{1'b0, 2'd0, 128'h0, 128'h0},
    '{1'b0, 2'd3, {128{1'b1}}, {128{1'b1}}},
    '{1'b1, 2'd0, 128'h12345678_9ABCDEF0_0BADF00D_FEEDFACE, 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0},
    '{1'b1, 2'd2, {128{1'b1}}, 128'hFFFFFFFF_01020304_05060708_090A0B0C}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_i = 1'b0;
  logic [1:0]   fn_i = 2'd0;
  logic [127:0] state_i = '0;
  logic [127:0] msg_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sha1_quad_round u0 (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .op_i (op_i), .fn_i (fn_i),
    .state_i (state_i), .msg_i (msg_i), .valid_o (valid_o), .result_o (result_o)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] kk(int g);
    if (g == 0) return 32'h5A827999;
    if (g == 1) return 32'h6ED9EBA1;
    if (g == 2) return 32'h8F1BBCDC;
    return 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] ff(int g, logic [31:0] b, logic [31:0] c, logic [31:0] d);
    if (g == 0) return (b & c) | (~b & d);
    if (g == 2) return (b & c) | (b & d) | (c & d);
    return b ^ c ^ d;
  endfunction

  // five-variable model; w0 carries any pre-added E, e starts at zero
  function automatic logic [127:0] model(logic [127:0] st, logic [127:0] m, int g);
    logic [31:0] a, b, c, d, e, t;
    a = st[127:96]; b = st[95:64]; c = st[63:32]; d = st[31:0]; e = 32'h0;
    for (int i = 0; i < 4; i++) begin
      t = rl(a, 5) + ff(g, b, c, d) + e + kk(g) + m[127-32*i -: 32];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {a, b, c, d};
  endfunction

  function automatic logic [127:0] fold_model(logic [127:0] st, logic [127:0] m);
    return {m[127:96] + rl(st[127:96], 30), m[95:0]};
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic op, logic [1:0] fn, logic [127:0] st, logic [127:0] m);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; fn_i = fn; state_i = st; msg_i = m;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired got %0d exp <20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [127:0] exp, held, prev_st, st, m, grp;
    logic [31:0] e;
    string tag;

    repeat (3) @(negedge clk);
    check("R10 result in reset", result_o, 128'h0);
    check("R10 valid in reset", {127'h0, valid_o}, 128'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // table walk: R1-style rounds per select (R1 R2 R3 R4, with R5 chaining), fold (R6 R7), wrap (R11)
    for (int v = 0; v < NVEC; v++) begin
      issue(VECS[v].op, VECS[v].fn, VECS[v].st, VECS[v].msg);
      if (VECS[v].op) begin
        exp = fold_model(VECS[v].st, VECS[v].msg);
        tag = (v == NVEC-1) ? "R6 R7 R11 fold wrap" : "R6 R7 fold";
      end else begin
        exp = model(VECS[v].st, VECS[v].msg, int'(VECS[v].fn));
        case (VECS[v].fn)
          2'd0: tag = "R1 R5 Ch";
          2'd1: tag = "R2 R5 Parity1";
          2'd2: tag = "R3 R5 Maj";
          default: tag = (v == 5) ? "R4 R11 Parity3 wrap" : "R4 R5 Parity3";
        endcase
      end
      check(tag, result_o, exp);
      check("R8 valid one cycle", {127'h0, valid_o}, 128'h1);
    end

    // R8 / R9: idle cycles with changing inputs
    held = result_o;
    @(negedge clk);
    check("R8 valid drops", {127'h0, valid_o}, 128'h0);
    for (int i = 0; i < 3; i++) begin
      state_i = {4{$urandom()}}; msg_i = {4{$urandom()}}; op_i = i[0]; fn_i = i[1:0];
      @(negedge clk);
      check("R9 hold when idle", result_o, held);
    end

    // R5: E carried only by D into later rounds; only lane 0 of state differs
    issue(1'b0, 2'd1, 128'h1, 128'h0);
    exp = model(128'h1, 128'h0, 1);
    check("R5 D feeds E", result_o, exp);

    // chained groups: E passed through the fold operation
    st = {$urandom(), $urandom(), $urandom(), $urandom()};
    e = $urandom();
    prev_st = '0;
    for (int g = 0; g < 4; g++) begin
      m = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (g == 0) begin
        grp = {m[127:96] + e, m[95:0]};
      end else begin
        issue(1'b1, 2'd0, prev_st, m);
        check("R6 R7 chained fold", result_o, {m[127:96] + e, m[95:0]});
        grp = result_o;
      end
      issue(1'b0, g[1:0], st, grp);
      exp = model(st, grp, g);
      check("R1 R2 R3 R4 chained rounds", result_o, exp);
      // E for the next group is the rotated A at the start of this group
      e = rl(st[127:96], 30);
      prev_st = st;
      st = result_o;
    end

    // R10: asynchronous reset clears outputs
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R10 async clear", result_o, 128'h0);
    finish_run();
  end
endmodule